// File: doc/BRIEF.md
# Sample Trigger Offset Locator

This block finds the exact position of a trigger event inside a window of eight consecutive 16-bit logic samples. A coarse trigger stage elsewhere only knows that the event lies somewhere in the window. This block rescans the window one sample per cycle and reports the first sample index at which three conditions hold together:
- a masked pattern match;
- a rising edge on every bit of a rising mask;
- a falling edge on every bit of a falling mask.

Edge tests compare each sample with the one before it. For the first sample of the window, the sample that preceded the window is used.

Samples enter as a packed vector of bytes, two bytes per sample with the low byte first. The pattern value and the three masks are sampled together with the data when `start` is accepted. The scan then runs in the controller. The controller has three states:
- `ST_IDLE`: waits for `start`.
- `ST_SCAN`: tests one candidate per cycle.
- `ST_REPORT`: raises `done` for one cycle.

Its transitions are:
- IDLE→SCAN when `start` is high.
- SCAN→REPORT on the first passing index, or after the last index.
- REPORT→SCAN when `start` is high again in that cycle, which gives back-to-back scans.
- REPORT→IDLE otherwise.

A scan that finds no match still ends in REPORT. It reports `found` low, and the offset counter wraps to 0.

Top module: `trig_offset_locator`

## Requirements
- R1: After reset, `busy`, `done` and `found` are 0 and `offset` is 0.
- R2: `start` is accepted only in the idle state or in the cycle `done` is high. `busy` is high from the next cycle until `done`. A `start` while `busy` is high has no effect on the running scan or its result.
- R3: Candidate sample i (i = 0..7) is {`sample_bytes`[(2i+1)*8 +: 8], `sample_bytes`[2i*8 +: 8]}, so the low byte comes first in the byte vector.
- R4: The pattern test passes when (sample AND `pat_mask`) equals `pat_value`.
- R5: The rising test passes only if all `rise_mask` bits are 0 in the previous sample and all are 1 in the current sample.
- R6: The falling test passes only if all `fall_mask` bits are 1 in the previous sample and all are 0 in the current sample.
- R7: The previous sample of index 0 is `last_sample`. For index i>0 it is candidate i-1.
- R8: The lowest index k passing all three tests is reported with `found`=1 and `offset`=k. `done` rises in the (k+1)th cycle after the accepting edge.
- R9: If no index passes, `found`=0 and `offset`=0 (eight wrapped to three bits). `done` rises in the 8th cycle after the accepting edge.
- R10: A test whose mask is all zero always passes.
- R11: `done` is a single-cycle pulse. `found` and `offset` change only in a cycle where `done` is high, and they hold until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a scan of the presented window |
| sample_bytes | input | 128 | Eight samples as sixteen bytes, low byte first |
| last_sample | input | 16 | Sample preceding the window |
| pat_mask | input | 16 | Pattern compare mask |
| pat_value | input | 16 | Pattern compare value |
| rise_mask | input | 16 | Bits that must rise |
| fall_mask | input | 16 | Bits that must fall |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A passing index was located |
| offset | output | 3 | Located index (0 when none) |

## Verification
Two functions can fall in the same cycle: reporting a finished scan and accepting the next `start`. The bench raises `start` in the very cycle `done` is observed high. It then checks that the new scan begins without an idle cycle and that the previous result stayed visible for its full `done` cycle. The bench also pulses `start` in the middle of a running scan, with different data on the inputs. A reference model compares every cycle, so any effect of that pulse on timing or on the result is flagged.

// File: rtl/trig_loc_pkg.sv
package trig_loc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_REPORT = 2'd2
    } tl_state_e;

endpackage

// File: rtl/tl_unpack.sv
module tl_unpack #(
    parameter int N_SAMP = 8,
    parameter int SAMP_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [N_SAMP*SAMP_W-1:0]        bytes_in,
    output logic [N_SAMP-1:0][SAMP_W-1:0]   samples
);
    localparam int BYTES_PER_SAMP = SAMP_W / BYTE_W;

    // R3: byte b of sample i sits at byte position i*BYTES_PER_SAMP + b (low byte first)
    for (genvar i = 0; i < N_SAMP; i++) begin : g_samp
        for (genvar b = 0; b < BYTES_PER_SAMP; b++) begin : g_byte
            assign samples[i][b*BYTE_W +: BYTE_W] =
                bytes_in[(i*BYTES_PER_SAMP + b)*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/tl_cond.sv
module tl_cond #(
    parameter int SAMP_W = 16
) (
    input  logic [SAMP_W-1:0] cur,
    input  logic [SAMP_W-1:0] prev,
    input  logic [SAMP_W-1:0] pat_mask,
    input  logic [SAMP_W-1:0] pat_value,
    input  logic [SAMP_W-1:0] rise_mask,
    input  logic [SAMP_W-1:0] fall_mask,
    output logic              pass
);
    logic pat_ok, rise_ok, fall_ok;

    always_comb begin
        // R4 masked pattern
        pat_ok  = ((cur & pat_mask) == pat_value);
        // R5 every masked bit low before, high now
        rise_ok = ((prev & rise_mask) == '0) && ((cur & rise_mask) == rise_mask);
        // R6 every masked bit high before, low now
        fall_ok = ((prev & fall_mask) == fall_mask) && ((cur & fall_mask) == '0);
        pass    = pat_ok && rise_ok && fall_ok;
    end
endmodule

// File: rtl/tl_ctrl.sv
module tl_ctrl
    import trig_loc_pkg::*;
#(
    parameter int N_SAMP = 8,
    parameter int IDX_W  = $clog2(N_SAMP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N_SAMP-1:0] hit_vec,
    output logic              load,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic [IDX_W-1:0]  offset
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SAMP - 1);
    localparam logic [IDX_W-1:0] NONE_OFF = IDX_W'(N_SAMP);   // count wraps

    tl_state_e        state, state_nx;
    logic [IDX_W-1:0] idx;
    logic             hit_now, scan_end;

    always_comb begin
        hit_now  = hit_vec[idx];
        scan_end = (state == ST_SCAN) && (hit_now || (idx == LAST_IDX));
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_SCAN;
            ST_SCAN:   if (hit_now || (idx == LAST_IDX)) state_nx = ST_REPORT;
            ST_REPORT: state_nx = start ? ST_SCAN : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        busy = (state == ST_SCAN);
        done = (state == ST_REPORT);
        load = start && ((state == ST_IDLE) || (state == ST_REPORT));
    end

    // index counter and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= '0;
            found  <= 1'b0;
            offset <= '0;
        end else begin
            if (load)
                idx <= '0;
            else if ((state == ST_SCAN) && !scan_end)
                idx <= idx + 1'b1;
            if (scan_end) begin
                found  <= hit_now;
                offset <= hit_now ? idx : NONE_OFF;
            end
        end
    end

    // checker-side count of busy cycles
    logic [IDX_W:0] busy_cycles;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_cycles <= '0;
        else if (busy) busy_cycles <= busy_cycles + 1'b1;
        else           busy_cycles <= '0;
    end

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(found) && $stable(offset)));

    // R9
    nomatch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (offset == '0));

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R8
    scan_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cycles < (IDX_W+1)'(N_SAMP)));
endmodule

// File: rtl/trig_offset_locator.sv
module trig_offset_locator #(
    parameter int N_SAMP = 8,
    parameter int SAMP_W = 16,
    parameter int BYTE_W = 8,
    localparam int IDX_W = $clog2(N_SAMP),
    localparam int VEC_W = N_SAMP * SAMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VEC_W-1:0]  sample_bytes,
    input  logic [SAMP_W-1:0] last_sample,
    input  logic [SAMP_W-1:0] pat_mask,
    input  logic [SAMP_W-1:0] pat_value,
    input  logic [SAMP_W-1:0] rise_mask,
    input  logic [SAMP_W-1:0] fall_mask,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic [IDX_W-1:0]  offset
);
    logic                            load;
    logic [VEC_W-1:0]                bytes_q;
    logic [SAMP_W-1:0]               last_q, pmask_q, pval_q, rmask_q, fmask_q;
    logic [N_SAMP-1:0][SAMP_W-1:0]   samples;
    logic [N_SAMP-1:0]               hit_vec;

    // operand capture on an accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bytes_q <= '0;
            last_q  <= '0;
            pmask_q <= '0;
            pval_q  <= '0;
            rmask_q <= '0;
            fmask_q <= '0;
        end else if (load) begin
            bytes_q <= sample_bytes;
            last_q  <= last_sample;
            pmask_q <= pat_mask;
            pval_q  <= pat_value;
            rmask_q <= rise_mask;
            fmask_q <= fall_mask;
        end
    end

    tl_unpack #(.N_SAMP(N_SAMP), .SAMP_W(SAMP_W), .BYTE_W(BYTE_W)) u_unpack (
        .bytes_in (bytes_q),
        .samples  (samples)
    );

    // R7: history chain, index 0 sees the sample before the window
    for (genvar i = 0; i < N_SAMP; i++) begin : g_cond
        logic [SAMP_W-1:0] prev_s;
        if (i == 0) begin : g_first
            assign prev_s = last_q;
        end else begin : g_rest
            assign prev_s = samples[i-1];
        end
        tl_cond #(.SAMP_W(SAMP_W)) u_cond (
            .cur       (samples[i]),
            .prev      (prev_s),
            .pat_mask  (pmask_q),
            .pat_value (pval_q),
            .rise_mask (rmask_q),
            .fall_mask (fmask_q),
            .pass      (hit_vec[i])
        );
    end

    tl_ctrl #(.N_SAMP(N_SAMP)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .hit_vec (hit_vec),
        .load    (load),
        .busy    (busy),
        .done    (done),
        .found   (found),
        .offset  (offset)
    );

    // R2
    load_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |-> !load);
endmodule

// File: tb/test_trig_offset_locator.sv
module test_trig_offset_locator;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] bytes_in = '0;
    logic [15:0]  last_s = '0, pm = '0, pv = '0, rm = '0, fm = '0;
    logic         busy, done, found;
    logic [2:0]   offset;

    logic [15:0]  smp [8];
    int           n_checks = 0;
    int           n_errors = 0;
    string        cur_tag = "R1";
    bit           finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_offset_locator i_trig_offset_locator (
        .clk(clk), .rst_n(rst_n), .start(start), .sample_bytes(bytes_in),
        .last_sample(last_s), .pat_mask(pm), .pat_value(pv),
        .rise_mask(rm), .fall_mask(fm),
        .busy(busy), .done(done), .found(found), .offset(offset)
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference: first passing index, 8 when none
    function automatic int ref_scan(input logic [127:0] b, input logic [15:0] last,
                                    input logic [15:0] m_p, v_p, m_r, m_f);
        logic [15:0] prev, cur;
        prev = last;
        for (int i = 0; i < 8; i++) begin
            cur = {b[16*i+8 +: 8], b[16*i +: 8]};   // low byte first
            if (((cur & m_p) == v_p) && ((prev & m_r) == 0) && ((cur & m_r) == m_r)
                && ((prev & m_f) == m_f) && ((cur & m_f) == 0))
                return i;
            prev = cur;
        end
        return 8;
    endfunction

    // cycle-by-cycle model
    bit m_busy = 0, m_done = 0, m_found = 0;
    int m_off = 0, m_cnt = 0, p_pos = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_found = 0; m_off = 0; m_cnt = 0;
        end else begin
            bit nd;
            nd = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy  = 0;
                    nd      = 1;
                    m_found = (p_pos < 8);
                    m_off   = p_pos % 8;
                end
            end else if (start) begin
                p_pos  = ref_scan(bytes_in, last_s, pm, pv, rm, fm);
                m_cnt  = (p_pos == 8) ? 8 : p_pos + 1;
                m_busy = 1;
            end
            m_done = nd;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(cur_tag, int'(busy),   int'(m_busy),  "busy (model)");
            check(cur_tag, int'(done),   int'(m_done),  "done (model)");
            check(cur_tag, int'(found),  int'(m_found), "found (model)");
            check(cur_tag, int'(offset), m_off,         "offset (model)");
        end
    end

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !finished) begin
            finished = 1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual %0d expected <= 20000 cycles", wd);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic pack();
        for (int i = 0; i < 8; i++) begin
            bytes_in[16*i +: 8]   = smp[i][7:0];
            bytes_in[16*i+8 +: 8] = smp[i][15:8];
        end
    endtask

    task automatic fill(input logic [15:0] v);
        for (int i = 0; i < 8; i++) smp[i] = v;
    endtask

    // called at a negedge; returns at the negedge where done is seen
    task automatic run_case(input string tag, input int exp_pos);
        int lat;
        cur_tag = tag;
        pack();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(tag, lat, (exp_pos == 8) ? 8 : exp_pos + 1, "latency");
        check(tag, int'(found), int'(exp_pos < 8), "found");
        check(tag, int'(offset), exp_pos % 8, "offset");
    endtask

    initial begin
        fill(16'h0000);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", int'(busy), 0, "busy");
        check("R1", int'(done), 0, "done");
        check("R1", int'(found), 0, "found");
        check("R1", int'(offset), 0, "offset");
        rst_n = 1'b1;
        @(negedge clk);

        // R10 all masks zero: index 0 passes
        pm = 0; pv = 0; rm = 0; fm = 0; fill(16'h5a5a);
        run_case("R10", 0);
        @(negedge clk);

        // R4 pattern on high byte at index 5
        fill(16'h1100); smp[5] = 16'h3c77; smp[6] = 16'h3c00;
        pm = 16'hff00; pv = 16'h3c00;
        run_case("R4", 5);
        @(negedge clk);

        // R3 byte order: swapped value at 1 must not match, proper at 4
        fill(16'h0000); smp[1] = 16'hab12; smp[4] = 16'h12ab;
        pm = 16'hffff; pv = 16'h12ab;
        run_case("R3", 4);
        @(negedge clk);

        // R5 rising on two bits
        pm = 0; pv = 0; rm = 16'h0011; last_s = 16'h0000;
        fill(16'h0000); smp[0] = 16'h0010; smp[1] = 16'h0000; smp[2] = 16'h0011;
        run_case("R5", 2);
        @(negedge clk);

        // R7 index 0 uses last_sample as history
        rm = 16'h8000; fill(16'h0000); smp[0] = 16'h8000; smp[2] = 16'h8000;
        last_s = 16'h0000;
        run_case("R7", 0);
        @(negedge clk);
        last_s = 16'h8000;
        run_case("R7", 2);
        @(negedge clk);

        // R6 falling on two bits
        rm = 0; fm = 16'h0300; last_s = 16'h0000;
        fill(16'h0000); smp[0] = 16'h0300; smp[1] = 16'h0100; smp[2] = 16'h0300; smp[3] = 16'h0000;
        run_case("R6", 3);
        @(negedge clk);

        // R9 no match: offset wraps to 0
        fm = 0; pm = 16'hffff; pv = 16'h1234; fill(16'h4321);
        run_case("R9", 8);
        @(negedge clk);

        // R8 match on the last index, all three tests combined
        pm = 16'h00f0; pv = 16'h00a0; rm = 16'h0001; fm = 16'h0002; last_s = 16'h0000;
        fill(16'h00a2); smp[6] = 16'h00a2; smp[7] = 16'h00a1;
        run_case("R8", 7);

        // R11 / R2 back-to-back: start in the done cycle
        pm = 0; pv = 0; rm = 0; fm = 0; fill(16'h0000);
        run_case("R11", 0);
        @(negedge clk);

        // R2 start while busy is ignored
        cur_tag = "R2";
        pm = 16'hffff; pv = 16'h0777; fill(16'h0000); smp[5] = 16'h0777;
        pack();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        pv = 16'h0000; fill(16'h0000); pack();   // would match at 0
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            int w;
            w = 0;
            while (!done && w < 20) begin @(negedge clk); w++; end
            check("R2", int'(found), 1, "found after ignored start");
            check("R2", int'(offset), 5, "offset after ignored start");
        end
        @(negedge clk);
        check("R2", int'(busy), 0, "idle after scan");
        check("R11", int'(offset), 5, "offset held");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule